// File: doc/BRIEF.md
# Streaming 8x8 Forward Integer Cosine Transform

This block turns a stream of 8x8 pixel blocks into unnormalized two-dimensional transform coefficients. The kernel approximates the cosine basis with small integers (magnitudes 10, 9, 6 and 2 on the odd basis rows, 3 and 1 on rows 2 and 6, and plus or minus one on rows 0 and 4). Every product is therefore a short shift-and-add, and no multiplier is needed. The transform is separable. A row pass works on each complete pixel row, a two-bank transpose store holds the row results, and a column pass reads them back one column at a time.

Pixels enter one per clock in row-major order, with a marker on the first pixel of a block. Blocks may follow each other with no idle cycle, and the output then runs without a break. Before the row pass, a pair gatherer packs two pixels into one word, so the row logic updates at most every second clock. Coefficients leave one per clock in column-major (transposed) order, each block led by a start flag. Quantization, scaling and the inverse transform belong to the neighbouring blocks.

Top module: `ict2d_fwd`

## Requirements
- R1: After reset, out_valid and out_sop are low and out_data is zero, and they stay so until a full block of 64 pixels has been accepted.
- R2: A pixel is accepted when in_valid is high. Accepted pixel number k of a block (k = 0..63) is X[k/8][k%8], meaning row k/8 and column k%8. A pixel accepted with in_sop high has k = 0. After k = 63 the count wraps to 0, so a following block needs no marker. Pixels are paired internally before the row pass.
- R3: The n-th coefficient of a block (n = 0..63) is Y[n%8][n/8], where Y = K·X·Kᵀ in exact integer arithmetic and K is the kernel of R4.
- R4: Let s_i = x_i + x_(7-i) and d_i = x_i - x_(7-i). The kernel rows are:
  - K0 = s0+s1+s2+s3 and K4 = s0-s1-s2+s3.
  - K2 = 3(s0-s3)+(s1-s2) and K6 = (s0-s3)-3(s1-s2).
  - K1 = 10d0+9d1+6d2+2d3 and K3 = 9d0-2d1-10d2-6d3.
  - K5 = 6d0-10d1+2d2+9d3 and K7 = 2d0-6d1+9d2-10d3.
- R5: in_data is two's-complement with IN_W bits (9 by default). out_data is two's-complement with IN_W+12 bits (21 by default). Results are exact for all inputs, including blocks of all maximum values, all minimum values and checkerboards of the two.
- R6: The first coefficient of a block is on the outputs after the 4th rising edge following the edge that accepts the block's 64th pixel.
- R7: Blocks fed with no idle cycle between pixels give an unbroken output run of exactly 64·N cycles for N blocks.
- R8: out_sop is high together with out_valid on the first coefficient of each block, and low at all other times.
- R9: Cycles with in_valid low change nothing: in_sop and in_data are ignored in those cycles, and the results equal those of the same block sent without gaps.
- R10: A block cut short by a new in_sop yields no coefficients. The restarted block is transformed normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Pixel on in_data is accepted this cycle |
| in_sop | input | 1 | Accepted pixel is the first of a block |
| in_data | input | IN_W | Signed pixel value |
| out_valid | output | 1 | Coefficient on out_data is valid |
| out_sop | output | 1 | First coefficient of a block |
| out_data | output | IN_W+12 | Signed unnormalized coefficient |

## Verification
A wrong pixel index or a wrong pair slot corrupts whole kernel columns. It shows in the first coefficients of that block, 4 cycles after its last pixel, and the bench catches it with impulse blocks at chosen positions. If the transpose store picks the wrong bank, or lets a bank be read before it is full, the ports show coefficients from the previous block, or values out of order, at some point within that block's 64-cycle output run. A slip in the bank hand-over shows as a hole in the otherwise unbroken output run, or as a start flag arriving one cycle off its fixed latency.

// File: rtl/ict_pkg.sv
package ict_pkg;
    localparam int PTS   = 8;
    localparam int BLK   = PTS * PTS;
    localparam int PTW   = $clog2(PTS);
    localparam int IDXW  = $clog2(BLK);
    localparam int PAIRS = PTS / 2;
    localparam int SLOTW = $clog2(PAIRS);
    // one bit for the butterfly, five for a coefficient sum below 32
    localparam int GROW  = 6;
endpackage

// File: rtl/ict_kernel1d.sv
module ict_kernel1d import ict_pkg::*; #(
    parameter int IW = 9,
    parameter int OW = IW + GROW
) (
    input  logic signed [IW-1:0] x [PTS],
    output logic signed [OW-1:0] y [PTS]
);
    typedef logic signed [OW-1:0] acc_t;

    function automatic acc_t by10(acc_t v);
        return (v <<< 3) + (v <<< 1);
    endfunction
    function automatic acc_t by9(acc_t v);
        return (v <<< 3) + v;
    endfunction
    function automatic acc_t by6(acc_t v);
        return (v <<< 2) + (v <<< 1);
    endfunction
    function automatic acc_t by3(acc_t v);
        return (v <<< 1) + v;
    endfunction
    function automatic acc_t by2(acc_t v);
        return v <<< 1;
    endfunction

    acc_t sm [PAIRS];
    acc_t df [PAIRS];
    acc_t ev_a, ev_b, ev_p, ev_q;

    always_comb begin
        for (int k = 0; k < PAIRS; k++) begin
            sm[k] = acc_t'(x[k]) + acc_t'(x[PTS-1-k]);
            df[k] = acc_t'(x[k]) - acc_t'(x[PTS-1-k]);
        end
        ev_a = sm[0] + sm[3];
        ev_b = sm[1] + sm[2];
        ev_p = sm[0] - sm[3];
        ev_q = sm[1] - sm[2];
        y[0] = ev_a + ev_b;
        y[4] = ev_a - ev_b;
        y[2] = by3(ev_p) + ev_q;
        y[6] = ev_p - by3(ev_q);
        y[1] = by10(df[0]) + by9(df[1]) + by6(df[2]) + by2(df[3]);
        y[3] = by9(df[0]) - by2(df[1]) - by10(df[2]) - by6(df[3]);
        y[5] = by6(df[0]) - by10(df[1]) + by2(df[2]) + by9(df[3]);
        y[7] = by2(df[0]) - by6(df[1]) + by9(df[2]) - by10(df[3]);
    end
endmodule

// File: rtl/ict_row_gather.sv
module ict_row_gather import ict_pkg::*; #(
    parameter int IW = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic                    in_sop,
    input  logic [IW-1:0]           in_data,
    output logic                    row_vld,
    output logic [PTW-1:0]          row_num,
    output logic [PTS-1:0][IW-1:0]  row_bits
);
    typedef struct packed {
        logic [IDXW-1:0]         idx;
        logic [IW-1:0]           lo;
        logic                    pv;
        logic [IW-1:0]           plo;
        logic [IW-1:0]           phi;
        logic [IDXW-2:0]         pidx;
        logic [PTS-1:0][IW-1:0]  rbuf;
        logic                    rv;
        logic [PTW-1:0]          rnum;
    } gst_t;

    gst_t st_d, st_q;
    logic [IDXW-1:0]  cur_idx;
    logic [SLOTW-1:0] slot;

    always_comb begin
        st_d    = st_q;
        st_d.pv = 1'b0;
        st_d.rv = 1'b0;
        cur_idx = in_sop ? '0 : st_q.idx;
        slot    = st_q.pidx[SLOTW-1:0];
        // full-rate side: pack two pixels into one half-rate word
        if (in_valid) begin
            if (!cur_idx[0]) begin
                st_d.lo = in_data;
            end else begin
                st_d.pv   = 1'b1;
                st_d.plo  = st_q.lo;
                st_d.phi  = in_data;
                st_d.pidx = cur_idx[IDXW-1:1];
            end
            st_d.idx = cur_idx + IDXW'(1);
        end
        // half-rate side: place the pair into the row buffer
        if (st_q.pv) begin
            st_d.rbuf[{slot, 1'b0}] = st_q.plo;
            st_d.rbuf[{slot, 1'b1}] = st_q.phi;
            if (slot == SLOTW'(PAIRS - 1)) begin
                st_d.rv   = 1'b1;
                st_d.rnum = st_q.pidx[IDXW-2:SLOTW];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign row_vld  = st_q.rv;
    assign row_num  = st_q.rnum;
    assign row_bits = st_q.rbuf;

    AST_HALF_RATE_PAIRS: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pv |=> !st_q.pv); // R2
    AST_ROW_FOLLOWS_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.rv |-> $past(st_q.pv)); // R2
endmodule

// File: rtl/ict_transpose.sv
module ict_transpose import ict_pkg::*; #(
    parameter int DW = 15
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [PTW-1:0]        wr_row,
    input  logic signed [DW-1:0]  wr_vec [PTS],
    output logic                  rd_vld,
    output logic                  rd_first,
    output logic [PTW-1:0]        rd_sel,
    output logic signed [DW-1:0]  col_vec [PTS]
);
    typedef struct packed {
        logic            wsel;
        logic            rsel;
        logic [1:0]      full;
        logic            active;
        logic [IDXW-1:0] oc;
    } tst_t;

    tst_t st_d, st_q;
    logic signed [DW-1:0] mem_q [2][PTS][PTS];
    logic [PTW-1:0] col_u;

    always_comb begin
        st_d = st_q;
        if (wr_en && wr_row == PTW'(PTS - 1)) begin
            st_d.full[st_q.wsel] = 1'b1;
            st_d.wsel            = ~st_q.wsel;
        end
        if (st_q.active) begin
            st_d.oc = st_q.oc + IDXW'(1);
            if (st_q.oc == IDXW'(BLK - 1)) begin
                st_d.full[st_q.rsel] = 1'b0;
                st_d.rsel            = ~st_q.rsel;
                st_d.active          = st_q.full[~st_q.rsel];
            end
        end else if (st_q.full[st_q.rsel]) begin
            st_d.active = 1'b1;
            st_d.oc     = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            for (int c = 0; c < PTS; c++) begin
                mem_q[st_q.wsel][wr_row][c] <= wr_vec[c];
            end
        end
    end

    assign col_u = st_q.oc[IDXW-1:PTW];

    always_comb begin
        for (int r = 0; r < PTS; r++) begin
            col_vec[r] = mem_q[st_q.rsel][r][col_u];
        end
    end

    assign rd_vld   = st_q.active;
    assign rd_first = st_q.active && (st_q.oc == '0);
    assign rd_sel   = st_q.oc[PTW-1:0];

    AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !st_q.full[st_q.wsel]); // R7
    AST_READ_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.active |-> st_q.full[st_q.rsel]); // R7
endmodule

// File: rtl/ict2d_fwd.sv
module ict2d_fwd import ict_pkg::*; #(
    parameter  int IN_W  = 9,
    localparam int ROW_W = IN_W + GROW,
    localparam int OUT_W = ROW_W + GROW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_sop,
    input  logic [IN_W-1:0]  in_data,
    output logic             out_valid,
    output logic             out_sop,
    output logic [OUT_W-1:0] out_data
);
    typedef struct packed {
        logic             vld;
        logic             sop;
        logic [OUT_W-1:0] data;
    } ost_t;

    logic                      row_vld;
    logic [PTW-1:0]            row_num;
    logic [PTS-1:0][IN_W-1:0]  row_bits;
    logic signed [IN_W-1:0]    row_x [PTS];
    logic signed [ROW_W-1:0]   row_y [PTS];
    logic                      rd_vld, rd_first;
    logic [PTW-1:0]            rd_sel;
    logic signed [ROW_W-1:0]   col_x [PTS];
    logic signed [OUT_W-1:0]   col_y [PTS];
    ost_t st_d, st_q;

    ict_row_gather #(.IW(IN_W)) u_gather (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_sop   (in_sop),
        .in_data  (in_data),
        .row_vld  (row_vld),
        .row_num  (row_num),
        .row_bits (row_bits)
    );

    always_comb begin
        for (int c = 0; c < PTS; c++) begin
            row_x[c] = $signed(row_bits[c]);
        end
    end

    ict_kernel1d #(.IW(IN_W), .OW(ROW_W)) u_row_pass (
        .x (row_x),
        .y (row_y)
    );

    ict_transpose #(.DW(ROW_W)) u_tpose (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (row_vld),
        .wr_row   (row_num),
        .wr_vec   (row_y),
        .rd_vld   (rd_vld),
        .rd_first (rd_first),
        .rd_sel   (rd_sel),
        .col_vec  (col_x)
    );

    ict_kernel1d #(.IW(ROW_W), .OW(OUT_W)) u_col_pass (
        .x (col_x),
        .y (col_y)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = rd_vld;
        st_d.sop = rd_first;
        if (rd_vld) st_d.data = col_y[rd_sel];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign out_sop   = st_q.sop;
    assign out_data  = st_q.data;

    AST_RUN_STARTS_AT_SOP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> out_sop); // R8
    AST_SOP_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        out_sop |-> out_valid); // R8
endmodule

// File: tb/tb_ict2d_fwd.sv
`timescale 1ns/1ps
module tb_ict2d_fwd;
    localparam int IW = 9;
    localparam int OW = IW + 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_sop = 1'b0;
    logic [IW-1:0] in_data = '0;
    logic          out_valid, out_sop;
    logic [OW-1:0] out_data;

    ict2d_fwd #(.IN_W(IW)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
        .in_data(in_data), .out_valid(out_valid), .out_sop(out_sop),
        .out_data(out_data)
    );

    always #2.5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int    val;
        bit    sop;
        string tag;
    } exp_t;

    exp_t  exp_q[$];
    int    lat_q[$];
    exp_t  got;
    int    n_chk = 0;
    int    n_fail = 0;
    int    last_out_cyc = 0;
    int    run_first = 0;
    int    X [8][8];
    int    K [8][8] = '{
        '{ 1,  1,  1,  1,  1,  1,  1,  1},
        '{10,  9,  6,  2, -2, -6, -9,-10},
        '{ 3,  1, -1, -3, -3, -1,  1,  3},
        '{ 9, -2,-10, -6,  6, 10,  2, -9},
        '{ 1, -1, -1,  1,  1, -1, -1,  1},
        '{ 6,-10,  2,  9, -9, -2, 10, -6},
        '{ 1, -3,  3, -1, -1,  3, -3,  1},
        '{ 2, -6,  9,-10, 10, -9,  6, -2}};

    task automatic check(bit ok, string req, string what, int act, int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    function automatic void push_expected(string tag);
        int   rp [8][8];
        exp_t e;
        for (int r = 0; r < 8; r++)
            for (int u = 0; u < 8; u++) begin
                rp[r][u] = 0;
                for (int c = 0; c < 8; c++) rp[r][u] += K[u][c] * X[r][c];
            end
        for (int u = 0; u < 8; u++)
            for (int v = 0; v < 8; v++) begin
                e.val = 0;
                for (int r = 0; r < 8; r++) e.val += K[v][r] * rp[r][u];
                e.sop = (u == 0) && (v == 0);
                e.tag = tag;
                exp_q.push_back(e);
            end
    endfunction

    function automatic void fill_const(int v);
        for (int r = 0; r < 8; r++)
            for (int c = 0; c < 8; c++) X[r][c] = v;
    endfunction

    function automatic void fill_random();
        for (int r = 0; r < 8; r++)
            for (int c = 0; c < 8; c++) X[r][c] = int'($urandom_range(511)) - 256;
    endfunction

    // count pixels from X in row-major order; a full block records when its first coefficient is due
    task automatic drive_pixels(int cnt, bit gaps);
        for (int k = 0; k < cnt; k++) begin
            if (gaps) begin
                while ($urandom_range(2) == 0) begin
                    @(negedge clk);
                    in_valid = 1'b0;
                    in_sop   = 1'($urandom_range(1));
                    in_data  = IW'($urandom);
                end
            end
            @(negedge clk);
            in_valid = 1'b1;
            in_sop   = (k == 0);
            in_data  = IW'(X[k/8][k%8]);
            // accepted at the next edge (cyc+1); first coefficient 4 edges later
            if (cnt == 64 && k == 63) lat_q.push_back(cyc + 5);
        end
    endtask

    task automatic go_idle();
        @(negedge clk);
        in_valid = 1'b0;
        in_sop   = 1'b0;
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            last_out_cyc = cyc;
            if (exp_q.size() == 0) begin
                check(1'b0, "R10", "coefficient with nothing pending", int'($signed(out_data)), 0);
            end else begin
                got = exp_q.pop_front();
                check(int'($signed(out_data)) == got.val, got.tag, "coefficient",
                      int'($signed(out_data)), got.val);
                check(out_sop == got.sop, "R8", "block-start flag", int'(out_sop), int'(got.sop));
                if (got.sop && lat_q.size() != 0) begin
                    int due;
                    due = lat_q.pop_front();
                    check(cyc == due, "R6", "first-coefficient cycle", cyc, due);
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "WATCHDOG", "run did not finish", cyc, 0);
        report();
        $finish;
    end

    initial begin
        void'($urandom(32'd8086));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: quiet outputs after reset
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            check(out_valid == 1'b0, "R1", "out_valid idle", int'(out_valid), 0);
            check(out_sop == 1'b0, "R1", "out_sop idle", int'(out_sop), 0);
            check(out_data == '0, "R1", "out_data idle", int'($signed(out_data)), 0);
        end

        // back-to-back run of ten blocks: extremes, impulses, random
        for (int b = 0; b < 10; b++) begin
            string tag;
            tag = "R3";
            case (b)
                0: begin fill_const(255);  tag = "R5"; end
                1: begin fill_const(-256); tag = "R5"; end
                2, 3: begin
                    for (int r = 0; r < 8; r++)
                        for (int c = 0; c < 8; c++)
                            X[r][c] = (((r + c + b) % 2) == 0) ? 255 : -256;
                    tag = "R5";
                end
                4: begin fill_const(0); X[0][1] = 1;  tag = "R4"; end
                5: begin fill_const(0); X[2][5] = -7; tag = "R2"; end
                default: fill_random();
            endcase
            push_expected(tag);
            drive_pixels(64, 1'b0);
            if (b == 0) run_first = lat_q[lat_q.size() - 1];
        end
        go_idle();
        drain();
        // R7: ten blocks give one unbroken 640-cycle output run
        check(last_out_cyc - run_first == 639, "R7", "length of output run",
              last_out_cyc - run_first + 1, 640);

        // R9: idle cycles with junk on in_sop and in_data
        for (int b = 0; b < 3; b++) begin
            fill_random();
            push_expected("R9");
            drive_pixels(64, 1'b1);
        end
        go_idle();
        drain();

        // R10: abandoned block followed by a restarted full block
        fill_random();
        drive_pixels(20, 1'b0);
        fill_random();
        push_expected("R10");
        drive_pixels(64, 1'b0);
        go_idle();
        drain();
        repeat (80) @(negedge clk);
        check(exp_q.size() == 0, "R10", "pending coefficients", exp_q.size(), 0);
        check(lat_q.size() == 0, "R10", "pending block starts", lat_q.size(), 0);

        report();
        $finish;
    end
endmodule